// File: doc/BRIEF.md
# Burst Memory Responder

This block is a slave on a memory-mapped bus with a wait-request handshake. It stands in for the memory behind a processor's instruction and data ports. It holds a small word array and accepts single writes, write bursts and read bursts. Read bursts are recorded in a short command queue and answered later, one data beat per cycle, each beat marked by a valid strobe.

A mode input picks the read-burst address order. In instruction mode the burst starts at the requested word and wraps inside its 32-byte line. In data mode the address steps up by one word per beat. Write bursts always step linearly.

A stall input turns on pseudo-random back-pressure from an LFSR. Both command acceptance and beat delivery then go ahead only on about 100 of every 128 cycles. This exercises a master's tolerance of an irregular slave.

Top module: `brsp_burst_responder`

## Requirements
- R1: A command is taken only at a clock edge where `read` or `write` is high and `ready` is high; a write offered while `ready` is low leaves the array unchanged, and `read` and `write` are never high together.
- R2: While `rst_n` is low, `ready` is high, and after a reset edge `rdata_valid` is low.
- R3: Each accepted read returns exactly `burst_count` beats (1 to 2^BURST_W-1), `rdata_valid` high for one cycle per beat, bursts answered in acceptance order; `rdata` is meaningless while `rdata_valid` is low.
- R4: With `mode_wrap`=1, each next read beat address is `(a & ~(LINE_BYTES-1)) | ((a + 4) & (LINE_BYTES-1))`, so a burst never leaves its 32-byte line.
- R5: With `mode_wrap`=1, accepted read addresses are word aligned (`address[1:0]`=0), and the first beat returned is the word at the requested address.
- R6: Write beat n of a burst goes to the first beat's address + 4*n; `byte_en[i]` enables data bits [8i+7:8i]; `address` and `burst_count` count only on the first beat, and after `burst_count` beats the next write starts a new burst.
- R7: With `mode_wrap`=0, read beat n comes from base + 4*n, modulo the 2^ADDR_W byte address space.
- R8: With `stall_en`=0, `ready` is high whenever the queue is not full and a pending beat is sent every cycle; with `stall_en`=1, each of the two is allowed on roughly 100/128 of cycles.
- R9: The queue holds QDEPTH outstanding read bursts; while it is full, `ready` is low.
- R10: `mode_wrap` must not change while any read burst is outstanding; a change made while idle applies to the next bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_wrap | input | 1 | 1: read bursts wrap in a line; 0: read bursts increment |
| stall_en | input | 1 | Enables pseudo-random stall injection |
| read | input | 1 | Read command request |
| write | input | 1 | Write beat request |
| address | input | ADDR_W | Byte address (first beat of a burst) |
| burst_count | input | BURST_W | Beats in the burst |
| byte_en | input | DATA_W/8 | Write byte lane enables |
| wdata | input | DATA_W | Write data |
| ready | output | 1 | High when a command is taken this cycle (not wait-request) |
| rdata_valid | output | 1 | Read beat present on `rdata` |
| rdata | output | DATA_W | Read beat data |

## Verification
The bench uses the defaults: a 64-word array on an 8-bit byte address, 4-bit burst counts, a four-deep queue and 32-byte lines. Four back-to-back 8-beat reads therefore fill the queue while the first is still draining. This makes the full-queue stall, and a write ignored during it, directly observable. The small address space lets linear bursts run past the top address and come back to zero. It also lets random bursts hit every line, so wrap and linear orders both cross line ends, from any critical word.

// File: rtl/brsp_pkg.sv
// Shared types of the burst memory responder.
// Assumes: nothing beyond the compilation order (this file first).
package brsp_pkg;

    // Order in which a read burst visits addresses.
    typedef enum logic {
        BRSP_LINEAR = 1'b0,
        BRSP_WRAP   = 1'b1
    } brsp_mode_e;

endpackage

// File: rtl/brsp_stall_gen.sv
// Pseudo-random go/stall generator.
// A Fibonacci LFSR advances every cycle. Two disjoint RAND_W-bit windows of it
// give independent permissions for command acceptance and beat delivery.
// Each permission is granted when its window is below PASS_LIMIT, or always
// when stalling is disabled.
// Assumes: LFSR_W >= 2*RAND_W, a maximal tap mask and a non-zero seed.
module brsp_stall_gen #(
    parameter int unsigned             LFSR_W     = 16,
    parameter int unsigned             RAND_W     = 7,
    parameter int unsigned             PASS_LIMIT = 100,
    parameter logic [LFSR_W-1:0]       TAPS       = 'hB400,
    parameter logic [LFSR_W-1:0]       SEED       = 'hACE1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic cmd_go,
    output logic rsp_go
);
    logic [LFSR_W-1:0] state_q;
    logic              fb;

    assign fb = ^(state_q & TAPS);

    // Advance the LFSR each cycle; restart from the seed on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEED;
        else        state_q <= {state_q[LFSR_W-2:0], fb};
    end

    // Grant each permission from its own window of the state.
    always_comb begin
        cmd_go = !enable || (state_q[RAND_W-1:0] < RAND_W'(PASS_LIMIT));
        rsp_go = !enable || (state_q[2*RAND_W-1:RAND_W] < RAND_W'(PASS_LIMIT));
    end

    // R8: a zero state would freeze the stall pattern.
    assert_lfsr_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);

endmodule

// File: rtl/brsp_cmd_queue.sv
// Circular queue of outstanding read bursts.
// Entries are written at the tail. The head entry can be rewritten in place,
// so the reader counts down the beats and moves the beat address there.
// Popping the head takes priority over rewriting it.
// Assumes: push is never requested while full.
module brsp_cmd_queue #(
    parameter int unsigned W     = 12,
    parameter int unsigned DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         upd,
    input  logic [W-1:0] upd_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     slots_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] cnt_q;

    // Step a pointer with wrap at DEPTH.
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign head  = slots_q[rd_ptr_q];
    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CNT_W'(DEPTH));

    // Store a new tail entry and the rewritten head entry.
    always_ff @(posedge clk) begin
        if (push)        slots_q[wr_ptr_q] <= push_data;
        if (upd && !pop) slots_q[rd_ptr_q] <= upd_data;
    end

    // Maintain pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (push) wr_ptr_q <= bump(wr_ptr_q);
            if (pop)  rd_ptr_q <= bump(rd_ptr_q);
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + CNT_W'(1);
                2'b01:   cnt_q <= cnt_q - CNT_W'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R9: no entry is pushed into a full queue.
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R3: beats are only consumed from a non-empty queue.
    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop || upd) |-> !empty);

endmodule

// File: rtl/brsp_mem_array.sv
// Word array with one byte-enabled write port and one combinational read port.
// Built as one byte-wide array per lane, so each enable drives its own storage.
// Assumes: contents are undefined until written (no reset of storage).
module brsp_mem_array #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 6
) (
    input  logic                clk,
    input  logic                we,
    input  logic [IDX_W-1:0]    widx,
    input  logic [DATA_W/8-1:0] be,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [IDX_W-1:0]    ridx,
    output logic [DATA_W-1:0]   rdata
);
    localparam int unsigned LANES = DATA_W / 8;
    localparam int unsigned WORDS = 1 << IDX_W;

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        logic [7:0] lane_q [WORDS];

        // Write this lane when its byte enable is set.
        always_ff @(posedge clk) begin
            if (we && be[b]) lane_q[widx] <= wdata[b*8 +: 8];
        end

        assign rdata[b*8 +: 8] = lane_q[ridx];
    end

endmodule

// File: rtl/brsp_burst_responder.sv
// Burst memory responder: slave with not-wait-request handshake and a word array.
// Writes land in the array as they are accepted, stepping linearly within a burst.
// Reads are queued and answered one registered beat per cycle, in wrapping or
// linear order as chosen by mode_wrap. stall_en adds pseudo-random back-pressure.
// Assumes: the master never raises read and write together, never sends a
// zero burst count, aligns wrapping reads, and keeps mode_wrap steady while
// reads are outstanding.
module brsp_burst_responder #(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned BURST_W    = 4,
    parameter int unsigned QDEPTH     = 4,
    parameter int unsigned LINE_BYTES = 32,
    parameter int unsigned RAND_W     = 7,
    parameter int unsigned PASS_LIMIT = 100,
    parameter int unsigned LFSR_W     = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_wrap,
    input  logic                stall_en,
    input  logic                read,
    input  logic                write,
    input  logic [ADDR_W-1:0]   address,
    input  logic [BURST_W-1:0]  burst_count,
    input  logic [DATA_W/8-1:0] byte_en,
    input  logic [DATA_W-1:0]   wdata,
    output logic                ready,
    output logic                rdata_valid,
    output logic [DATA_W-1:0]   rdata
);
    import brsp_pkg::*;

    localparam int unsigned BE_W    = DATA_W / 8;
    localparam int unsigned BYTE_SH = $clog2(BE_W);
    localparam int unsigned IDX_W   = ADDR_W - BYTE_SH;
    localparam int unsigned ENT_W   = ADDR_W + BURST_W;
    localparam int unsigned LINE_SH = $clog2(LINE_BYTES);
    localparam int unsigned OWED_W  = BURST_W + $clog2(QDEPTH + 1) + 1;
    localparam logic [ADDR_W-1:0] LINE_M = ADDR_W'(LINE_BYTES - 1);
    localparam logic [ADDR_W-1:0] STEP   = ADDR_W'(BE_W);

    brsp_mode_e         mode;
    logic               cmd_go, rsp_go;
    logic               q_full, q_empty, beat_go, beat_pop;
    logic               acc_rd, acc_wr;
    logic [ENT_W-1:0]   head, upd_ent;
    logic [ADDR_W-1:0]  h_addr, lin_next, wrap_next;
    logic [BURST_W-1:0] h_left;
    logic [DATA_W-1:0]  mem_rd;

    logic [BURST_W-1:0] wr_beat_q, wr_len_q, wr_len;
    logic [IDX_W-1:0]   wr_base_q, wr_base, wr_idx;
    logic               wr_first, wr_last;
    logic               rdata_valid_q;
    logic [DATA_W-1:0]  rdata_q;

    assign mode = brsp_mode_e'(mode_wrap);

    brsp_stall_gen #(
        .LFSR_W     (LFSR_W),
        .RAND_W     (RAND_W),
        .PASS_LIMIT (PASS_LIMIT)
    ) u_stall (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (stall_en),
        .cmd_go (cmd_go),
        .rsp_go (rsp_go)
    );

    // Command handshake: high in reset, low while full or stalled.
    always_comb begin
        ready  = !rst_n || (!q_full && cmd_go);
        acc_rd = rst_n && read && ready;
        acc_wr = rst_n && write && ready;
    end

    // Write burst addressing: the first beat supplies base and length.
    always_comb begin
        wr_first = (wr_beat_q == '0);
        wr_len   = wr_first ? burst_count : wr_len_q;
        wr_base  = wr_first ? address[ADDR_W-1:BYTE_SH] : wr_base_q;
        wr_idx   = wr_base + IDX_W'(wr_beat_q);
        wr_last  = ((wr_beat_q + BURST_W'(1)) == wr_len);
    end

    // Track the beat position inside the current write burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_beat_q <= '0;
            wr_len_q  <= '0;
            wr_base_q <= '0;
        end else if (acc_wr) begin
            wr_beat_q <= wr_last ? '0 : wr_beat_q + BURST_W'(1);
            if (wr_first) begin
                wr_len_q  <= burst_count;
                wr_base_q <= address[ADDR_W-1:BYTE_SH];
            end
        end
    end

    brsp_cmd_queue #(
        .W     (ENT_W),
        .DEPTH (QDEPTH)
    ) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (acc_rd),
        .push_data ({address, burst_count}),
        .upd       (beat_go),
        .upd_data  (upd_ent),
        .pop       (beat_pop),
        .head      (head),
        .empty     (q_empty),
        .full      (q_full)
    );

    // Beat issue from the queue head, with the next address by mode.
    always_comb begin
        h_addr    = head[ENT_W-1:BURST_W];
        h_left    = head[BURST_W-1:0];
        lin_next  = h_addr + STEP;
        wrap_next = (h_addr & ~LINE_M) | (lin_next & LINE_M);
        beat_go   = !q_empty && rsp_go;
        beat_pop  = beat_go && (h_left == BURST_W'(1));
        upd_ent   = {(mode == BRSP_WRAP) ? wrap_next : lin_next,
                     h_left - BURST_W'(1)};
    end

    brsp_mem_array #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_mem (
        .clk   (clk),
        .we    (acc_wr),
        .widx  (wr_idx),
        .be    (byte_en),
        .wdata (wdata),
        .ridx  (h_addr[ADDR_W-1:BYTE_SH]),
        .rdata (mem_rd)
    );

    // Register each issued beat onto the read data port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_valid_q <= 1'b0;
            rdata_q       <= '0;
        end else begin
            rdata_valid_q <= beat_go;
            if (beat_go) rdata_q <= mem_rd;
        end
    end

    assign rdata_valid = rdata_valid_q;
    assign rdata       = rdata_q;

    // ---------------- assertions ----------------
    logic [OWED_W-1:0] owed_q;

    // Count beats promised to the master and not yet delivered.
    always_ff @(posedge clk) begin
        if (!rst_n) owed_q <= '0;
        else owed_q <= owed_q + (acc_rd ? OWED_W'(burst_count) : '0)
                              - OWED_W'(rdata_valid_q);
    end

    // R1: commands are exclusive.
    assert_one_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(read && write));

    // R1: no write beat advances the burst without a handshake.
    assert_write_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(write && ready) |=> $stable(wr_beat_q));

    // R3: burst counts are non-zero, and no beat appears that was not requested.
    assert_count_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (read && ready) |-> burst_count != '0);
    assert_beats_owed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |-> owed_q != '0);

    // R4: a wrapping burst stays inside its line.
    assert_wrap_in_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_go && mode_wrap && h_left > BURST_W'(1)) |=>
        h_addr[ADDR_W-1:LINE_SH] == $past(h_addr[ADDR_W-1:LINE_SH]));

    // R5: wrapping reads arrive word aligned.
    assert_fetch_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (read && ready && mode_wrap) |-> address[BYTE_SH-1:0] == '0);

    // R8: without stall injection the slave neither stalls nor withholds beats.
    assert_no_stall_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_en && !q_full) |-> ready);
    assert_no_stall_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_en && !q_empty) |=> rdata_valid);

    // R9: a full queue holds off new commands.
    assert_full_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q_full |-> !ready);

    // R10: the burst order is fixed while reads are outstanding.
    assert_mode_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !q_empty |-> $stable(mode_wrap));

endmodule

// File: tb/tb_brsp_burst_responder.sv
// Bench: directed corners plus seeded random bursts, against a memory model.
module tb_brsp_burst_responder;
    localparam int ADDR_W = 8, DATA_W = 32, BURST_W = 4, QDEPTH = 4, LINE_B = 32;
    localparam int WORDS  = 1 << (ADDR_W - 2);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_wrap = 1'b0, stall_en = 1'b1, read = 1'b0, write = 1'b0;
    logic [ADDR_W-1:0]  address = '0;
    logic [BURST_W-1:0] burst_count = '0;
    logic [3:0]         byte_en = '0;
    logic [DATA_W-1:0]  wdata = '0;
    logic ready, rdata_valid;
    logic [DATA_W-1:0] rdata;

    always #4 clk = ~clk;

    brsp_burst_responder #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BURST_W(BURST_W),
        .QDEPTH(QDEPTH), .LINE_BYTES(LINE_B)
    ) dut (
        .clk(clk), .rst_n(rst_n), .mode_wrap(mode_wrap), .stall_en(stall_en),
        .read(read), .write(write), .address(address), .burst_count(burst_count),
        .byte_en(byte_en), .wdata(wdata), .ready(ready),
        .rdata_valid(rdata_valid), .rdata(rdata)
    );

    int checks = 0, fails = 0;
    logic [DATA_W-1:0] model [WORDS];
    logic [DATA_W-1:0] exp_q [$];
    string             tag_q [$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a,
                                                    input bit wrap);
        logic [ADDR_W-1:0] m = ADDR_W'(LINE_B - 1);
        logic [ADDR_W-1:0] n = a + ADDR_W'(4);
        return wrap ? ((a & ~m) | (n & m)) : n;
    endfunction

    // Compare each returned beat with the next expected word (R3 order).
    always @(negedge clk) begin
        if (rst_n && rdata_valid) begin
            if (exp_q.size() == 0) check(1'b0, "R3", "unrequested beat", rdata, '0);
            else begin
                logic [DATA_W-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rdata === e, t, "read beat", rdata, e);
            end
        end
    end

    task automatic wr_burst(input logic [ADDR_W-1:0] base, input int n, input bit rnd_be);
        for (int i = 0; i < n; i++) begin
            logic [DATA_W-1:0] d = $urandom;
            logic [3:0] be = rnd_be ? 4'($urandom) : 4'hF;
            logic [ADDR_W-1:0] a = base + ADDR_W'(4 * i);
            @(negedge clk);
            write = 1'b1; wdata = d; byte_en = be;
            address = (i == 0) ? base : ADDR_W'($urandom);
            burst_count = (i == 0) ? BURST_W'(n) : BURST_W'($urandom);
            while (!ready) @(negedge clk);
            for (int b = 0; b < 4; b++)
                if (be[b]) model[a[ADDR_W-1:2]][b*8 +: 8] = d[b*8 +: 8];
        end
        @(negedge clk);
        write = 1'b0;
    endtask

    task automatic rd_burst(input logic [ADDR_W-1:0] base, input int n, input string tag);
        logic [ADDR_W-1:0] a = base;
        @(negedge clk);
        read = 1'b1; address = base; burst_count = BURST_W'(n);
        while (!ready) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(model[a[ADDR_W-1:2]]);
            tag_q.push_back(tag);
            a = next_addr(a, mode_wrap);
        end
        @(negedge clk);
        read = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0 && !rdata_valid, "R3", "beats beyond burst count",
              32'(rdata_valid), 32'd0);
    endtask

    task automatic set_mode(input bit wrap, input bit stall);
        @(negedge clk);
        mode_wrap = wrap; stall_en = stall;
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd7331));
        // R2: state while in reset and after reset edges
        repeat (3) @(negedge clk);
        check(ready === 1'b1, "R2", "ready in reset", 32'(ready), 32'd1);
        check(rdata_valid === 1'b0, "R2", "rdata_valid after reset", 32'(rdata_valid), 32'd0);
        rst_n = 1'b1;
        set_mode(1'b0, 1'b0);

        // R8: idle without stall injection never stalls
        begin
            int low = 0;
            repeat (200) begin @(negedge clk); if (!ready) low++; end
            check(low == 0, "R8", "stall cycles with injection off", 32'(low), 32'd0);
        end

        // Fill the array, one linear burst per line
        for (int l = 0; l < WORDS / 8; l++) wr_burst(ADDR_W'(l * 32), 8, 1'b0);

        // R7: linear read running past the top of the address space
        rd_burst(8'hF8, 4, "R7");
        drain();

        // R6: burst crossing a line, then a second burst right after
        wr_burst(8'h1C, 4, 1'b1);
        wr_burst(8'h60, 3, 1'b1);
        rd_burst(8'h18, 6, "R6");
        rd_burst(8'h5C, 5, "R6");
        drain();

        // R4 / R5: wrapping bursts from a critical word
        set_mode(1'b1, 1'b0);
        rd_burst(8'h5C, 8, "R4");
        rd_burst(8'h48, 1, "R5");
        rd_burst(8'hA4, 3, "R4");
        drain();

        // R9 and R1: fill the queue, offer a write while it is full
        for (int k = 0; k < QDEPTH; k++) rd_burst(ADDR_W'(k * 32), 8, "R4");
        check(ready === 1'b0, "R9", "ready with full queue", 32'(ready), 32'd0);
        write = 1'b1; address = 8'h84; burst_count = 1; byte_en = 4'hF;
        wdata = ~model[8'h84 >> 2];
        @(negedge clk);
        write = 1'b0;
        drain();
        set_mode(1'b0, 1'b0);
        rd_burst(8'h84, 1, "R1");
        drain();

        // R10: mode switched while idle applies to the following bursts
        set_mode(1'b1, 1'b0);
        rd_burst(8'hE8, 6, "R10");
        drain();
        set_mode(1'b0, 1'b0);
        rd_burst(8'hE8, 6, "R10");
        drain();

        // R8: acceptance rate with injection on, over an idle window
        set_mode(1'b0, 1'b1);
        begin
            int hi = 0;
            repeat (2048) begin @(negedge clk); if (ready) hi++; end
            check(hi > 1350 && hi < 1800, "R8", "ready cycles of 2048 with injection",
                  32'(hi), 32'd1600);
        end

        // Random phases: writes, then reads, in random mode and stall setting
        for (int it = 0; it < 60; it++) begin
            bit wrap = 1'($urandom);
            set_mode(wrap, 1'($urandom));
            for (int w = 0; w < 1 + int'($urandom_range(1, 0)); w++)
                wr_burst(ADDR_W'($urandom) & 8'hFC, int'($urandom_range(8, 1)), 1'b1);
            for (int r = 0; r < int'($urandom_range(5, 1)); r++)
                rd_burst(ADDR_W'($urandom) & 8'hFC, int'($urandom_range(8, 1)),
                         wrap ? "R4 random" : "R7 random");
            drain();
        end

        finish_run();
    end

endmodule